// File: doc/BRIEF.md
# Synthesizer Control Latch Sequencer

This block takes 24-bit control words from a three-wire serial port: a serial clock, serial data and a load strobe. It decodes the address held in the lowest two bits of each word and writes the word into one of four destinations. The destinations are the reference-divider word, the feedback-divider word, the function settings, and an initialization entry that writes the function settings and also starts a reset sequence. The serial pins are brought into the system clock domain through synchronizers before any decode.

From the stored settings the block drives the control lines for the divider counters and the charge pump. These are a counter hold, a charge-pump three-state, a power-down, and a one-cycle internal reset pulse. The pulse fires on each initialization write. It fires once more on the first feedback-divider write after that, and on no later one. The power-down has two sources. One is immediate and comes from the chip-enable pin. The other is synchronous and rides on the initialization pulse. All stored words survive power-down, so software does not need to write them again.

Top module: `synth_ctl_seq`

## Requirements
- R1: The word address in bits [1:0] selects the destination: 00 reference word, 01 feedback word, 10 function settings, 11 initialization. A write leaves every other destination unchanged.
- R2: Serial data is shifted in MSB first on rising serial-clock edges. The word is transferred on the rising edge of the load strobe. Bits [23:2] form the stored reference or feedback word (ref_word, n_word).
- R3: Function fields, by word bit: [2] counter hold, [3] synchronous power-down enable, [4] power-down mode (1 = asynchronous), [5] charge-pump three-state, [6] phase-detector polarity, [9:7] current A, [12:10] current B, [14:13] prescaler select. The polarity, currents and prescaler appear on their own outputs.
- R4: An initialization write loads the same function fields as a function write. It also raises int_rst for exactly one system clock cycle.
- R5: After an initialization write, the first feedback-word write raises int_rst again for one cycle. Later feedback writes, and feedback writes with no prior initialization, do not raise it.
- R6: cp_tristate is high when the three-state bit is 1, when the counter-hold bit is 1, during int_rst, and from reset until the first function or initialization write.
- R7: counter_reset is high while the counter-hold bit is 1 and during int_rst. The counter-hold bit by itself never raises power_down.
- R8: An initialization write made with chip_en high, enable bit 1 and mode bit 0 raises power_down during its int_rst cycle. With the mode bit 1, it does not.
- R9: chip_en low raises power_down at once, without waiting for a clock. Stored words are kept and can still be written while chip_en is low.
- R10: After reset, every stored word and field is zero, int_rst and counter_reset are low, and cp_tristate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low forces immediate power-down |
| ref_word | output | 22 | Stored reference-divider word |
| n_word | output | 22 | Stored feedback-divider word |
| cp_cur_a | output | 3 | Charge-pump current setting A |
| cp_cur_b | output | 3 | Charge-pump current setting B |
| presc_sel | output | 2 | Prescaler select |
| pd_polarity | output | 1 | Phase-detector polarity |
| cp_tristate | output | 1 | Charge-pump output three-state |
| counter_reset | output | 1 | Holds the divider counters at their load point |
| power_down | output | 1 | Power-down request |
| int_rst | output | 1 | One-cycle internal reset pulse |

## Verification
The hardest condition to reach is the armed state: an initialization has happened and the next feedback write is the one that pulses. A single-cycle pulse is easy to miss by sampling, so the bench counts every int_rst cycle with a monitor. The monitor also records the widest pulse and checks that charge-pump three-state, counter hold and, where the settings ask for it, synchronous power-down hold during that cycle. The stimulus walks a fixed order of serial writes: initialization, feedback, feedback, reference. It then starts a fresh initialization and compares the pulse count after each step.

// File: rtl/synth_ctl_pkg.sv
`timescale 1ns/1ps
package synth_ctl_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    DST_REF  = 2'b00,
    DST_N    = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dst_e;

  // Occupies word bits [14:2]; field order is MSB first.
  typedef struct packed {
    logic [1:0] presc;
    logic [2:0] cur_b;
    logic [2:0] cur_a;
    logic       pol;
    logic       tri_cp;
    logic       pd_mode;
    logic       pd_sync;
    logic       cnt_rst;
  } func_t;

  localparam int FUNC_W = $bits(func_t);
endpackage

// File: rtl/synth_ctl_shift.sv
`timescale 1ns/1ps
module synth_ctl_shift #(
  parameter int WORD_W      = synth_ctl_pkg::WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word_o,
  output logic              stb_o
);
  localparam int TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] clk_sr, dat_sr, le_sr;
  logic [WORD_W-1:0]    shreg;
  logic                 clk_rise, le_rise;

  // Identical synchronizer chains keep data aligned with its clock edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr <= '0;
      dat_sr <= '0;
      le_sr  <= '0;
    end else begin
      clk_sr <= {clk_sr[SYNC_STAGES-1:0], ser_clk};
      dat_sr <= {dat_sr[SYNC_STAGES-1:0], ser_data};
      le_sr  <= {le_sr[SYNC_STAGES-1:0], ser_le};
    end
  end

  assign clk_rise = clk_sr[TAP] & ~clk_sr[TAP+1];
  assign le_rise  = le_sr[TAP]  & ~le_sr[TAP+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      word_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      if (clk_rise) shreg <= {shreg[WORD_W-2:0], dat_sr[TAP]};
      stb_o <= le_rise;
      if (le_rise) word_o <= shreg;
    end
  end

  // Needs a low sample between two highs, so strobes are never adjacent.
  p_stb_gap_r2: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);
endmodule

// File: rtl/synth_ctl_latches.sv
`timescale 1ns/1ps
module synth_ctl_latches
  import synth_ctl_pkg::*;
#(
  parameter int WORD_W = synth_ctl_pkg::WORD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic [WORD_W-1:0]        word,
  output logic [WORD_W-ADDR_W-1:0] ref_q,
  output logic [WORD_W-ADDR_W-1:0] n_q,
  output func_t                    func_q,
  output logic                     func_seen
);
  dst_e dst;
  assign dst = dst_e'(word[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q     <= '0;
      n_q       <= '0;
      func_q    <= '0;
      func_seen <= 1'b0;
    end else if (stb) begin
      unique case (dst)
        DST_REF:  ref_q <= word[WORD_W-1:ADDR_W];
        DST_N:    n_q   <= word[WORD_W-1:ADDR_W];
        DST_FUNC, DST_INIT: begin
          func_q    <= func_t'(word[ADDR_W +: FUNC_W]);
          func_seen <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(ref_q) && $stable(n_q) && $stable(func_q)));
endmodule

// File: rtl/synth_ctl_rstgen.sv
`timescale 1ns/1ps
module synth_ctl_rstgen
  import synth_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  dst_e dst,
  input  logic pd_sync,
  input  logic pd_mode,
  input  logic ce,
  output logic pulse_o,
  output logic sd_pulse_o
);
  logic arm_q;
  logic init_wr, n_wr;

  assign init_wr = stb && (dst == DST_INIT);
  assign n_wr    = stb && (dst == DST_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q      <= 1'b0;
      pulse_o    <= 1'b0;
      sd_pulse_o <= 1'b0;
    end else begin
      pulse_o    <= 1'b0;
      sd_pulse_o <= 1'b0;
      if (init_wr) begin
        pulse_o    <= 1'b1;
        arm_q      <= 1'b1;
        sd_pulse_o <= ce & pd_sync & ~pd_mode;
      end else if (n_wr && arm_q) begin
        pulse_o <= 1'b1;
        arm_q   <= 1'b0;
      end
    end
  end

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  p_arm_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (n_wr && arm_q) |=> (pulse_o && !arm_q));
  p_no_pulse_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
    (n_wr && !arm_q) |=> !pulse_o);
  p_sd_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    sd_pulse_o |-> pulse_o);
endmodule

// File: rtl/synth_ctl_seq.sv
`timescale 1ns/1ps
module synth_ctl_seq
  import synth_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  input  logic             chip_en,
  output logic [PAY_W-1:0] ref_word,
  output logic [PAY_W-1:0] n_word,
  output logic [2:0]       cp_cur_a,
  output logic [2:0]       cp_cur_b,
  output logic [1:0]       presc_sel,
  output logic             pd_polarity,
  output logic             cp_tristate,
  output logic             counter_reset,
  output logic             power_down,
  output logic             int_rst
);
  logic [WORD_W-1:0] word;
  logic              stb;
  func_t             func_q;
  func_t             func_in;
  logic              func_seen;
  logic              sd_pulse;

  synth_ctl_shift #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .word_o(word), .stb_o(stb)
  );

  synth_ctl_latches #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst(rst), .stb(stb), .word(word),
    .ref_q(ref_word), .n_q(n_word), .func_q(func_q), .func_seen(func_seen)
  );

  // Power-down bits come from the word being written, not the old settings.
  assign func_in = func_t'(word[ADDR_W +: FUNC_W]);

  synth_ctl_rstgen u_rstgen (
    .clk(clk), .rst(rst), .stb(stb), .dst(dst_e'(word[ADDR_W-1:0])),
    .pd_sync(func_in.pd_sync), .pd_mode(func_in.pd_mode), .ce(chip_en),
    .pulse_o(int_rst), .sd_pulse_o(sd_pulse)
  );

  assign cp_cur_a      = func_q.cur_a;
  assign cp_cur_b      = func_q.cur_b;
  assign presc_sel     = func_q.presc;
  assign pd_polarity   = func_q.pol;
  assign counter_reset = func_q.cnt_rst | int_rst;
  assign cp_tristate   = ~func_seen | func_q.tri_cp | func_q.cnt_rst | int_rst;
  // Chip enable acts without a clock; the synchronous source is registered.
  assign power_down    = ~chip_en | sd_pulse;
endmodule

// File: tb/synth_ctl_seq_tb.sv
`timescale 1ns/1ps
module synth_ctl_seq_tb;
  localparam int CLK_P = 10;
  localparam int SER_H = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic [21:0] ref_word, n_word;
  logic [2:0]  cp_cur_a, cp_cur_b;
  logic [1:0]  presc_sel;
  logic        pd_polarity, cp_tristate, counter_reset, power_down, int_rst;

  int checks = 0, errors = 0;
  int pulse_cnt = 0, run = 0, max_run = 0, tri_miss = 0, hold_miss = 0, sd_cnt = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  synth_ctl_seq u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .chip_en(chip_en), .ref_word(ref_word), .n_word(n_word),
    .cp_cur_a(cp_cur_a), .cp_cur_b(cp_cur_b), .presc_sel(presc_sel),
    .pd_polarity(pd_polarity), .cp_tristate(cp_tristate),
    .counter_reset(counter_reset), .power_down(power_down), .int_rst(int_rst)
  );

  always @(negedge clk) begin
    if (!rst && int_rst) begin
      pulse_cnt++;
      run++;
      if (run > max_run) max_run = run;
      if (!cp_tristate) tri_miss++;
      if (!counter_reset) hold_miss++;
      if (power_down && chip_en) sd_cnt++;
    end else run = 0;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w);
    ser_le = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      #SER_H ser_clk = 1'b1;
      #SER_H ser_clk = 1'b0;
    end
    #SER_H ser_le = 1'b1;
    #SER_H ser_le = 1'b0;
    repeat (6) @(posedge clk);
    #1;
  endtask

  function automatic logic [23:0] fword(input logic [1:0] a, input logic hold,
      input logic pdsync, input logic pdmode, input logic tri_b, input logic pol,
      input logic [2:0] ca, input logic [2:0] cb, input logic [1:0] ps);
    return {9'd0, ps, cb, ca, pol, tri_b, pdmode, pdsync, hold, a};
  endfunction

  task automatic t_reset();
    chk("R10 ref_word", ref_word, 0);
    chk("R10 n_word", n_word, 0);
    chk("R10 cur/presc/pol", {cp_cur_a, cp_cur_b, presc_sel, pd_polarity}, 0);
    chk("R10 cp_tristate", cp_tristate, 1);
    chk("R10 counter_reset", counter_reset, 0);
    chk("R10 int_rst", int_rst, 0);
  endtask

  task automatic t_ref_n();
    int p0 = pulse_cnt;
    send({22'h2A5A5A, 2'b00});
    chk("R2 ref_word msb-first", ref_word, 22'h2A5A5A);
    chk("R1 n_word untouched", n_word, 0);
    chk("R6 tristate until first function write", cp_tristate, 1);
    send({22'h13C0F1, 2'b01});
    chk("R1 n_word", n_word, 22'h13C0F1);
    chk("R1 ref_word untouched", ref_word, 22'h2A5A5A);
    chk("R5 no pulse without init", pulse_cnt - p0, 0);
  endtask

  task automatic t_func();
    send(fword(2'b10, 0, 0, 0, 0, 1, 3'd5, 3'd3, 2'd2));
    chk("R3 cp_cur_a", cp_cur_a, 5);
    chk("R3 cp_cur_b", cp_cur_b, 3);
    chk("R3 presc_sel", presc_sel, 2);
    chk("R3 pd_polarity", pd_polarity, 1);
    chk("R6 tristate released", cp_tristate, 0);
    chk("R7 counter_reset low", counter_reset, 0);
    chk("R1 ref kept", ref_word, 22'h2A5A5A);
    send(fword(2'b10, 1, 0, 0, 0, 0, 3'd1, 3'd6, 2'd1));
    chk("R7 hold raises counter_reset", counter_reset, 1);
    chk("R6 hold raises tristate", cp_tristate, 1);
    chk("R7 hold no power_down", power_down, 0);
    send(fword(2'b10, 0, 0, 0, 1, 0, 3'd1, 3'd6, 2'd1));
    chk("R6 tristate bit", cp_tristate, 1);
    chk("R7 counter_reset off", counter_reset, 0);
  endtask

  task automatic t_init_seq();
    int p0 = pulse_cnt, s0 = sd_cnt;
    send(fword(2'b11, 0, 0, 0, 0, 0, 3'd7, 3'd2, 2'd3));
    chk("R4 init pulse", pulse_cnt - p0, 1);
    chk("R4 init loads fields", {cp_cur_a, cp_cur_b, presc_sel}, {3'd7, 3'd2, 2'd3});
    chk("R4 pulse width", max_run, 1);
    chk("R6 tristate during pulse", tri_miss, 0);
    chk("R7 hold during pulse", hold_miss, 0);
    chk("R8 no sync pd without enable", sd_cnt - s0, 0);
    send({22'h00ABCD, 2'b01});
    chk("R5 first N after init pulses", pulse_cnt - p0, 2);
    send({22'h00ABCE, 2'b01});
    chk("R5 second N no pulse", pulse_cnt - p0, 2);
    send({22'h001111, 2'b00});
    chk("R5 ref no pulse", pulse_cnt - p0, 2);
    send(fword(2'b11, 0, 1, 0, 0, 0, 3'd0, 3'd0, 2'd0));
    chk("R8 sync pd during init pulse", sd_cnt - s0, 1);
    chk("R8 sync pd released", power_down, 0);
    send({22'h000001, 2'b01});
    chk("R5 re-armed after new init", pulse_cnt - p0, 4);
    chk("R8 first-N pulse no sync pd", sd_cnt - s0, 1);
    send(fword(2'b11, 0, 1, 1, 0, 0, 3'd0, 3'd0, 2'd0));
    chk("R8 mode bit blocks sync pd", sd_cnt - s0, 1);
    chk("R4 pulses stay one cycle", max_run, 1);
  endtask

  task automatic t_ce();
    send(fword(2'b10, 0, 0, 0, 0, 1, 3'd4, 3'd1, 2'd1));
    chip_en = 1'b0;
    #1;
    chk("R9 immediate power_down", power_down, 1);
    send({22'h3FFFFF, 2'b00});
    chk("R9 write during power_down", ref_word, 22'h3FFFFF);
    chip_en = 1'b1;
    #1;
    chk("R9 power_down released", power_down, 0);
    chk("R9 fields kept", {cp_cur_a, cp_cur_b, presc_sel, pd_polarity}, {3'd4, 3'd1, 2'd1, 1'b1});
    chk("R9 n_word kept", n_word, 22'h000001);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_ref_n();
    t_func();
    t_init_seq();
    t_ce();
    finish_run();
  end
endmodule